// File: doc/BRIEF.md
# Register-Write Serial Target with CRC-8 Frame Check

This block is a two-wire serial bus target (I2C signalling) that accepts register writes into a small on-chip register file. It samples the SCL and SDA lines with a system clock that runs far faster than the bus clock, at most 400 kHz. It recognises START and STOP conditions and answers a 7-bit address. That address is a fixed three-bit prefix followed by four strap inputs.

A write frame carries four bytes: the address byte with the direction bit, a register index, a data byte and a trailing CRC-8 check byte. The check byte protects everything sent since the last START. The target acknowledges the address, index and data bytes unconditionally once the address matches. It acknowledges the check byte only when the CRC is correct. The register is updated only after that final acknowledge, so a corrupted or interrupted frame never reaches the register file. The target pulls SDA low through an open-drain enable output and never drives it high.

Top module: `i2cw_pec_target`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and every register in `regs_o` reads 0.
- R2: The target answers only the address byte whose bits [7:1] equal binary 101 followed by `strap_i[3:0]` and whose bit 0 (direction) is 0. Any other address byte gets no ACK, and the rest of the frame is ignored until the next START.
- R3: After a matching address, the register-index byte and the data byte are each acknowledged on their 9th clock.
- R4: The check byte is CRC-8 with polynomial 0x07, initial value 0x00 at each START, processed MSB-first with no final XOR, over the address byte, the index byte and the data byte. A matching check byte is acknowledged on its 9th clock.
- R5: A check byte that does not match gets no ACK on its 9th clock, and no register changes.
- R6: Register `k` occupies `regs_o[8*k+7:8*k]`. It takes the data byte only after the acknowledged check byte of a frame whose index equals `k`. An index of NREG (16) or above is acknowledged but changes no register.
- R7: A START or STOP condition received before a frame's check byte is acknowledged aborts the frame, and nothing is written. A following frame is decoded normally, with its CRC restarted.
- R8: `sda_oe_o` changes only while the synchronised SCL is low, and it is released when the 9th clock of each byte falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 4 | Low four address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | NREG*8 | All registers, register k at bits 8k+7..8k |

## Verification
The hardest case to reach is a frame that has already been acknowledged through its data byte and is then cut short, by a repeated START or by a STOP. The CRC and the captured index and data are all valid at that point, so only the frame sequencing stands between them and a register write. The bench reaches this with its bus master: it sends a well-formed address, index and data, then issues the condition in place of the check byte. It then sends a complete, correct frame to a different register. That frame proves that the CRC was restarted and that the aborted register stayed at zero. The out-of-range index, the corrupted check byte and the wrong direction bit are each driven with otherwise correct frames, so that exactly one field decides the outcome.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_ACK   = 2'd2
  } phase_t;

  localparam logic [7:0] CRC_POLY = 8'h07;

  // one byte of CRC-8, MSB first, no reflection
  function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] stage [STAGES];
  logic [W-1:0] prev_q;

  // idle bus level is high, so every stage resets to 1
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '1;
      prev_q <= '1;
    end else begin
      stage[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      prev_q <= stage[STAGES-1];
    end
  end

  assign q_o      = stage[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/i2cw_crc8.sv
module i2cw_crc8 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc_o
);
  import i2cw_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc_o <= 8'h00;
    else if (en)    crc_o <= crc8_byte(crc_o, din);
  end
endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile #(
  parameter int NREG = 16,
  parameter int W    = 8,
  parameter int IW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  output logic [NREG*W-1:0] regs_o
);
  logic [W-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                             mem[g] <= '0;
      else if (we && int'(waddr) == g)     mem[g] <= wdata;
    end
    assign regs_o[g*W +: W] = mem[g];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (regs_o == '0));

  // R6
  range_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (we && int'(waddr) >= NREG) |=> $stable(regs_o));
endmodule

// File: rtl/i2cw_pec_target.sv
module i2cw_pec_target #(
  parameter int         NREG        = 16,
  parameter int         STRAP_W     = 4,
  parameter logic [2:0] ADDR_PREFIX = 3'b101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [3:0]        strap_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  import i2cw_pkg::*;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int LAST_B = 3;

  logic [1:0] ln_s, ln_p;
  logic scl_s, sda_s, scl_p, sda_p;

  i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d_i({scl_i, sda_i}), .q_o(ln_s), .q_prev_o(ln_p)
  );
  assign {scl_s, sda_s} = ln_s;
  assign {scl_p, sda_p} = ln_p;

  logic start_ev, stop_ev, scl_rise, scl_fall;
  assign start_ev = scl_s & scl_p &  sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p &  sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;

  phase_t             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [1:0]         idx_q;
  logic [BYTE_W-1:0]  shreg_q, sub_q, dat_q;
  logic               sda_oe_q;
  logic [7:0]         crc_q;

  logic byte_done, addr_hit, ack_now, crc_en, wr_en;
  assign byte_done = scl_fall && (phase_q == PH_SHIFT) && (cnt_q == CNT_W'(BYTE_W));
  assign addr_hit  = (shreg_q[7:1] == {ADDR_PREFIX, strap_i[STRAP_W-1:0]}) && !shreg_q[0];

  always_comb begin
    case (idx_q)
      2'd0:    ack_now = addr_hit;
      2'd3:    ack_now = (shreg_q == crc_q);
      default: ack_now = 1'b1;
    endcase
  end

  assign crc_en = byte_done && ack_now && (idx_q != 2'(LAST_B));
  assign wr_en  = scl_fall && (phase_q == PH_ACK) && (idx_q == 2'(LAST_B));

  i2cw_crc8 i_crc (
    .clk(clk), .rst(rst), .clr(start_ev), .en(crc_en), .din(shreg_q), .crc_o(crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      shreg_q  <= '0;
      sub_q    <= '0;
      dat_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (start_ev) begin
      phase_q  <= PH_SHIFT;
      cnt_q    <= '0;
      idx_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_ev) begin
      phase_q  <= PH_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_SHIFT: begin
          if (scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
          end else if (byte_done) begin
            if (ack_now) begin
              sda_oe_q <= 1'b1;
              phase_q  <= PH_ACK;
              if (idx_q == 2'd1) sub_q <= shreg_q;
              if (idx_q == 2'd2) dat_q <= shreg_q;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            cnt_q    <= '0;
            idx_q    <= idx_q + 2'd1;
            phase_q  <= (idx_q == 2'(LAST_B)) ? PH_IDLE : PH_SHIFT;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  i2cw_regfile #(.NREG(NREG), .W(BYTE_W), .IW(BYTE_W)) i_regs (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(sub_q), .wdata(dat_q), .regs_o(regs_o)
  );

  // R2
  addr_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_q && idx_q == 2'd0) |-> addr_hit);

  // R4
  pec_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_q && idx_q == 2'(LAST_B)) |-> (shreg_q == crc_q));

  // R6
  commit_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> sda_oe_q);

  // R8
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_q != $past(sda_oe_q)) |-> !scl_s);
endmodule

// File: tb/test_i2cw_pec_target.sv
module test_i2cw_pec_target;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NREG = 16;
  localparam time Q   = 625ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] strap = 4'b1010;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #10ns clk = ~clk;

  i2cw_pec_target #(.NREG(NREG)) i_i2cw_pec_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  bit done = 0;
  logic [7:0] exp_regs [NREG];

  // R8: the open-drain enable may move only while the bus clock is low
  always @(sda_oe) if (!rst && scl_m === 1'b1) oe_viol++;

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < NREG; k++) chk(req, 32'(regs[k*8 +: 8]), 32'(exp_regs[k]));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
    ack = ~sda_line;
    #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic frame(input logic [7:0] ab, input logic [7:0] sub, input logic [7:0] dat,
                       input logic [7:0] pec, output logic [3:0] acks);
    bus_start();
    send_byte(ab, acks[3]);
    send_byte(sub, acks[2]);
    send_byte(dat, acks[1]);
    send_byte(pec, acks[0]);
    bus_stop();
  endtask

  function automatic logic [7:0] good_pec(input logic [7:0] ab, input logic [7:0] sub, input logic [7:0] dat);
    return bcrc(bcrc(bcrc(8'h00, ab), sub), dat);
  endfunction

  function automatic logic [7:0] my_addr();
    return {3'b101, strap, 1'b0};
  endfunction

  task automatic t_reset();
    chk("R1 sda_oe after reset", 32'(sda_oe), 0);
    chk("R1 registers after reset", 32'(regs == '0), 1);
  endtask

  task automatic t_good_write();
    logic [3:0] a;
    logic [7:0] ab = my_addr();
    frame(ab, 8'd3, 8'hA5, good_pec(ab, 8'd3, 8'hA5), a);
    exp_regs[3] = 8'hA5;
    chk("R2 address ack", 32'(a[3]), 1);
    chk("R3 index and data ack", 32'(a[2:1]), 32'h3);
    chk("R4 good check byte ack", 32'(a[0]), 1);
    chk_regs("R6 register written");
  endtask

  task automatic t_bad_pec();
    logic [3:0] a;
    logic [7:0] ab = my_addr();
    frame(ab, 8'd3, 8'h3C, good_pec(ab, 8'd3, 8'h3C) ^ 8'h10, a);
    chk("R5 bad check byte acks", 32'(a), 32'b1110);
    chk_regs("R5 register unchanged");
  endtask

  task automatic t_wrong_addr();
    logic [3:0] a;
    logic [7:0] ab = {3'b101, strap ^ 4'b0001, 1'b0};
    frame(ab, 8'd4, 8'h99, good_pec(ab, 8'd4, 8'h99), a);
    chk("R2 wrong strap ignored", 32'(a), 0);
    ab = {3'b111, strap, 1'b0};
    frame(ab, 8'd4, 8'h99, good_pec(ab, 8'd4, 8'h99), a);
    chk("R2 wrong prefix ignored", 32'(a), 0);
    ab = my_addr() | 8'h01;
    frame(ab, 8'd4, 8'h99, good_pec(ab, 8'd4, 8'h99), a);
    chk("R2 direction bit 1 ignored", 32'(a), 0);
    chk_regs("R2 nothing written");
  endtask

  task automatic t_abort();
    logic [3:0] a;
    logic x;
    logic [7:0] ab = my_addr();
    bus_start();
    send_byte(ab, x);
    send_byte(8'd5, x);
    send_byte(8'h77, x);
    chk("R7 data ack before abort", 32'(x), 1);
    bus_start();
    send_byte(ab, a[3]);
    send_byte(8'd6, a[2]);
    send_byte(8'h11, a[1]);
    send_byte(good_pec(ab, 8'd6, 8'h11), a[0]);
    bus_stop();
    exp_regs[6] = 8'h11;
    chk("R7 frame after repeated start", 32'(a), 32'hF);
    bus_start();
    send_byte(ab, x);
    send_byte(8'd5, x);
    send_byte(8'h78, x);
    bus_stop();
    chk_regs("R7 aborted frames write nothing");
  endtask

  task automatic t_range();
    logic [3:0] a;
    logic [7:0] ab = my_addr();
    frame(ab, 8'h20, 8'hFF, good_pec(ab, 8'h20, 8'hFF), a);
    chk("R6 out-of-range index acks", 32'(a), 32'hF);
    frame(ab, 8'd16, 8'hEE, good_pec(ab, 8'd16, 8'hEE), a);
    chk_regs("R6 out-of-range index writes nothing");
  endtask

  task automatic t_strap_edge();
    logic [3:0] a;
    logic [7:0] ab;
    strap = 4'b0101;
    ab = my_addr();
    frame(ab, 8'd15, 8'h5A, good_pec(ab, 8'd15, 8'h5A), a);
    exp_regs[15] = 8'h5A;
    chk("R2 new strap address", 32'(a), 32'hF);
    frame(ab, 8'd0, 8'h00, good_pec(ab, 8'd0, 8'h00), a);
    chk("R4 all-zero payload check byte", 32'(a[0]), 1);
    chk_regs("R6 top register written");
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
    repeat (5) @(posedge clk);
    #1ns;
    t_reset();
    rst = 1'b0;
    #(4*Q);
    t_good_write();
    t_bad_pec();
    t_wrong_addr();
    t_abort();
    t_range();
    t_strap_edge();
    chk("R8 sda_oe moved while SCL high", 32'(oe_viol), 0);
    chk("R8 sda_oe released at end", 32'(sda_oe), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule